// File: doc/BRIEF.md
# Dual-Lane Serial Waveform Memory Loader

This block is the write path that fills a 4096-sample waveform memory over a serial port. It has two data lanes. The pin that normally returns read data instead becomes a second serial input. Both lanes share one serial clock and one active-low select. Each lane starts with its own 16-bit command word, which carries its own start address. After the command, each lane sends a stream of 16-bit data words. Because the two lanes move data at the same time, the memory fills twice as fast as it would over one lane. A full fill needs one command word and 2048 data words on each lane.

The block samples the serial pins with its system clock and finds the rising edges of the serial clock. It shifts each lane's bits MSB first. It keeps a separate address counter for each lane that steps once per data word. Only addresses inside the memory window are accepted. When both lanes finish a word on the same cycle, an arbiter passes the two writes, one after the other, into a single-port memory. A read port on the same memory serves the waveform player. Writes take the memory port first; reads wait. A mode input turns the second lane off, and the block then works as a plain single-lane loader.

Top module: `dual_lane_sram_writer`

## Requirements
- R1: The memory holds 4096 samples of 12 bits. Serial address A in 0x6000..0x6FFF maps to memory location A[11:0].
- R2: Each lane receives words MSB first, one bit per rising serial-clock edge while select is low. The first word is the command: bit 15 is the direction and bits 14:0 are the start address. Every later word is data, and the stored sample is data bits 15:4.
- R3: With dual mode on, both lanes load at once from independent start addresses. The second lane is input only: the block has no output on it.
- R4: Each lane's address steps by one after each data word, independently of the other lane.
- R5: When both lanes complete a word on the same cycle, the lane 0 sample is written first and the lane 1 sample one cycle later. If the two addresses are equal, the lane 1 value is the one that remains.
- R6: A lane's address counter is 12 bits and wraps inside the window: the word after 0x6FFF goes to 0x6000.
- R7: If a lane's command address lies outside the window, every data word of that transfer is dropped and `addr_err[lane]` goes high. The flag stays high until the next falling edge of select.
- R8: If a lane's command has bit 15 = 1 (read), that lane writes nothing for the rest of the transfer and raises no error.
- R9: While `dual_en` is low, lane 1 is ignored entirely: it writes nothing and raises no error.
- R10: A read request accepted while `rd_ready` is high returns `rd_valid` = 1 and the sample on `rd_data` one cycle later. `rd_ready` is low in any cycle in which a write uses the port.
- R11: After reset, `rd_valid` and `addr_err` are 0, `rd_ready` is 1, and both lanes wait for a command.
- R12: Raising select discards any partially received word. The next transfer starts again with a command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_en | input | 1 | 1 = second lane active |
| sclk | input | 1 | Serial clock, sampled by clk |
| cs_n | input | 1 | Active-low transfer select |
| sd_lane0 | input | 1 | Serial data, lane 0 |
| sd_lane1 | input | 1 | Serial data, lane 1 (the repurposed output pin) |
| rd_en | input | 1 | Read request from the waveform player |
| rd_addr | input | 12 | Read location |
| rd_ready | output | 1 | Port free for a read this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 12 | Sample read back |
| addr_err | output | 2 | Per-lane out-of-window flag |

## Verification
The pins go through one register stage, and each lane registers a completed word. A lane 0 sample therefore reaches memory on the third clock edge after the serial-clock edge that carried its last bit. A lane 1 sample held back by arbitration arrives one edge later, and an error flag appears on the second edge. The bench raises select and then waits eight clocks before it reads any location or the error flags, which is well past all of these latencies. Read data is due one edge after the request, so the bench drives `rd_en` on a falling clock edge and checks `rd_valid` and `rd_data` on the next falling edge. One full-memory fill with both lanes active is read back location by location. After that, targeted transfers cover overlap, wrap, window errors, read commands, single-lane mode and aborted words, and each one checks both the locations it should change and the ones it must leave alone.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int WORD_W = 16;
  localparam int SPI_AW = 15;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int NLANES = 2;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_SKIP = 2'd2
  } lane_phase_e;
endpackage

// File: rtl/dspi_lane.sv
module dspi_lane #(
  parameter int ADDR_W = 12,
  parameter int SAMPLE_W = 12,
  parameter logic [dspi_pkg::SPI_AW-1:0] WIN_BASE = 15'h6000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                csn,
  input  logic                start,
  input  logic                rise,
  input  logic                sd,
  output logic                wr_vld,
  output logic [ADDR_W-1:0]   wr_off,
  output logic [SAMPLE_W-1:0] wr_smp,
  output logic                err
);
  import dspi_pkg::*;

  lane_phase_e          phase_q, phase_n;
  logic [CNT_W-1:0]     bcnt_q, bcnt_n;
  logic [WORD_W-1:0]    sh_q, sh_n, sh_in;
  logic [ADDR_W-1:0]    off_q, off_n;
  logic                 win_q, win_n;
  logic                 vld_q, vld_n;
  logic [ADDR_W-1:0]    oo_q, oo_n;
  logic [SAMPLE_W-1:0]  os_q, os_n;
  logic                 err_q, err_n;
  logic                 step;
  logic                 last_bit;

  assign step     = rise & en & ~csn;
  assign sh_in    = {sh_q[WORD_W-2:0], sd};
  assign last_bit = (bcnt_q == CNT_W'(WORD_W - 1));

  always_comb begin
    phase_n = phase_q;
    bcnt_n  = bcnt_q;
    sh_n    = sh_q;
    off_n   = off_q;
    win_n   = win_q;
    vld_n   = 1'b0;
    oo_n    = oo_q;
    os_n    = os_q;
    err_n   = err_q;
    if (start) begin
      err_n = 1'b0;
    end
    if (csn || !en) begin
      phase_n = PH_CMD;
      bcnt_n  = '0;
    end else if (step) begin
      bcnt_n = bcnt_q + 1'b1;
      sh_n   = sh_in;
      if (last_bit) begin
        unique case (phase_q)
          PH_CMD: begin
            off_n   = sh_in[ADDR_W-1:0];
            win_n   = (sh_in[SPI_AW-1:ADDR_W] == WIN_BASE[SPI_AW-1:ADDR_W]);
            phase_n = sh_in[WORD_W-1] ? PH_SKIP : PH_DATA;
          end
          PH_DATA: begin
            if (win_q) begin
              vld_n = 1'b1;
              oo_n  = off_q;
              os_n  = sh_in[WORD_W-1 -: SAMPLE_W];
            end else begin
              err_n = 1'b1;
            end
            off_n = off_q + 1'b1;
          end
          default: phase_n = PH_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      bcnt_q  <= '0;
      sh_q    <= '0;
      off_q   <= '0;
      win_q   <= 1'b0;
      vld_q   <= 1'b0;
      oo_q    <= '0;
      os_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      bcnt_q  <= bcnt_n;
      sh_q    <= sh_n;
      off_q   <= off_n;
      win_q   <= win_n;
      vld_q   <= vld_n;
      oo_q    <= oo_n;
      os_q    <= os_n;
      err_q   <= err_n;
    end
  end

  assign wr_vld = vld_q;
  assign wr_off = oo_q;
  assign wr_smp = os_q;
  assign err    = err_q;
endmodule

// File: rtl/dspi_arb.sv
module dspi_arb #(
  parameter int ADDR_W = 12,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v0,
  input  logic [ADDR_W-1:0]   a0,
  input  logic [SAMPLE_W-1:0] d0,
  input  logic                v1,
  input  logic [ADDR_W-1:0]   a1,
  input  logic [SAMPLE_W-1:0] d1,
  output logic                we,
  output logic [ADDR_W-1:0]   waddr,
  output logic [SAMPLE_W-1:0] wdata,
  output logic                g0,
  output logic                g1,
  output logic                held
);
  logic                hv_q, hv_n;
  logic [ADDR_W-1:0]   ha_q, ha_n;
  logic [SAMPLE_W-1:0] hd_q, hd_n;
  logic                c1v;
  logic [ADDR_W-1:0]   c1a;
  logic [SAMPLE_W-1:0] c1d;

  assign c1v = hv_q | v1;
  assign c1a = hv_q ? ha_q : a1;
  assign c1d = hv_q ? hd_q : d1;

  always_comb begin
    hv_n  = hv_q;
    ha_n  = ha_q;
    hd_n  = hd_q;
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    g0    = 1'b0;
    g1    = 1'b0;
    if (v0) begin
      we    = 1'b1;
      waddr = a0;
      wdata = d0;
      g0    = 1'b1;
      hv_n  = c1v;
      ha_n  = c1a;
      hd_n  = c1d;
    end else if (c1v) begin
      we    = 1'b1;
      waddr = c1a;
      wdata = c1d;
      g1    = 1'b1;
      hv_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      ha_q <= '0;
      hd_q <= '0;
    end else begin
      hv_q <= hv_n;
      ha_q <= ha_n;
      hd_q <= hd_n;
    end
  end

  assign held = hv_q;
endmodule

// File: rtl/dspi_sram.sv
module dspi_sram #(
  parameter int ADDR_W = 12,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                re,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SAMPLE_W-1:0] wdata,
  output logic                rvalid,
  output logic [SAMPLE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] rd_q;
  logic                rv_q, rv_n;
  logic                rd_fire;

  assign rd_fire = re & ~we;
  assign rv_n    = rd_fire;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (rd_fire) begin
      rd_q <= mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= rv_n;
    end
  end

  assign rvalid = rv_q;
  assign rdata  = rd_q;
endmodule

// File: rtl/dual_lane_sram_writer.sv
module dual_lane_sram_writer #(
  parameter int ADDR_W = 12,
  parameter int SAMPLE_W = 12,
  parameter logic [dspi_pkg::SPI_AW-1:0] WIN_BASE = 15'h6000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dual_en,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                sd_lane0,
  input  logic                sd_lane1,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_ready,
  output logic                rd_valid,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic [1:0]          addr_err
);
  import dspi_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic              sclk_q, sclk_p, csn_q, csn_p;
  logic [NLANES-1:0] sd_q;
  logic              rise, start;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sclk_q <= 1'b0;
      sclk_p <= 1'b0;
      csn_q  <= 1'b1;
      csn_p  <= 1'b1;
      sd_q   <= '0;
    end else begin
      sclk_q <= sclk;
      sclk_p <= sclk_q;
      csn_q  <= cs_n;
      csn_p  <= csn_q;
      sd_q   <= {sd_lane1, sd_lane0};
    end
  end

  assign rise  = sclk_q & ~sclk_p;
  assign start = csn_p & ~csn_q;

  logic [NLANES-1:0]   l_vld;
  logic [ADDR_W-1:0]   l_off [NLANES];
  logic [SAMPLE_W-1:0] l_smp [NLANES];
  logic [NLANES-1:0]   l_err;
  logic [NLANES-1:0]   l_en;

  genvar gi;
  generate
    for (gi = 0; gi < NLANES; gi++) begin : g_lane
      if (gi == 0) begin : g_prim
        assign l_en[gi] = 1'b1;
      end else begin : g_sec
        assign l_en[gi] = dual_en;
      end
      dspi_lane #(
        .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .WIN_BASE(WIN_BASE)
      ) u_lane (
        .clk(clk), .rst_n(rst_i), .en(l_en[gi]), .csn(csn_q),
        .start(start), .rise(rise), .sd(sd_q[gi]),
        .wr_vld(l_vld[gi]), .wr_off(l_off[gi]), .wr_smp(l_smp[gi]),
        .err(l_err[gi])
      );
    end
  endgenerate

  logic                we, g0, g1, held;
  logic [ADDR_W-1:0]   waddr;
  logic [SAMPLE_W-1:0] wdata;

  dspi_arb #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_arb (
    .clk(clk), .rst_n(rst_i),
    .v0(l_vld[0]), .a0(l_off[0]), .d0(l_smp[0]),
    .v1(l_vld[1]), .a1(l_off[1]), .d1(l_smp[1]),
    .we(we), .waddr(waddr), .wdata(wdata),
    .g0(g0), .g1(g1), .held(held)
  );

  logic [ADDR_W-1:0] port_addr;
  assign port_addr = we ? waddr : rd_addr;
  assign rd_ready  = ~we;

  dspi_sram #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_mem (
    .clk(clk), .rst_n(rst_i), .we(we), .re(rd_en),
    .addr(port_addr), .wdata(wdata),
    .rvalid(rd_valid), .rdata(rd_data)
  );

  assign addr_err = l_err;
endmodule

// File: rtl/dspi_chk.sv
module dspi_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       dual_en,
  input logic       csn_q,
  input logic       start,
  input logic [1:0] l_vld,
  input logic       g0,
  input logic       g1,
  input logic       held,
  input logic       rd_en,
  input logic       rd_ready,
  input logic       rd_valid,
  input logic [1:0] addr_err
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r5_lane1_follows: assert property (@(posedge clk) disable iff (!rst_i)
    (l_vld[0] && l_vld[1]) |=> g1);

  a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_i)
    !(g0 && g1));

  a_r5_no_lost_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !(held && l_vld[1]));

  a_r9_lane1_silent: assert property (@(posedge clk) disable iff (!rst_i)
    (past_ok && !$past(dual_en)) |-> (!l_vld[1] && !$rose(addr_err[1])));

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_i)
    rd_valid |-> (past_ok && $past(rd_en && rd_ready)));

  a_r10_write_blocks_read: assert property (@(posedge clk) disable iff (!rst_i)
    (g0 || g1) |-> !rd_ready);

  a_r7_err_clears_on_start: assert property (@(posedge clk) disable iff (!rst_i)
    (past_ok && $fell(addr_err[0])) |-> $past(start));

  a_r12_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_i)
    (past_ok && $past(csn_q)) |-> (l_vld == 2'b00));
endmodule

bind dual_lane_sram_writer dspi_chk u_chk (
  .clk(clk), .rst_i(rst_i), .dual_en(dual_en), .csn_q(csn_q), .start(start),
  .l_vld(l_vld), .g0(g0), .g1(g1), .held(held), .rd_en(rd_en),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .addr_err(addr_err)
);

// File: tb/sim_dual_lane_sram_writer.sv
`timescale 1ns/1ps
module sim_dual_lane_sram_writer;
  logic        clk = 1'b0;
  logic        rst_n, dual_en, sclk, cs_n, sd0, sd1, rd_en;
  logic [11:0] rd_addr;
  logic        rd_ready, rd_valid;
  logic [11:0] rd_data;
  logic [1:0]  addr_err;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  logic [11:0] expm [4096];
  logic [1:0]  exp_err;

  always #2 clk = ~clk;

  dual_lane_sram_writer u0 (
    .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .sclk(sclk), .cs_n(cs_n),
    .sd_lane0(sd0), .sd_lane1(sd1), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .addr_err(addr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] dw(input int lane, input int seed, input int k);
    return 16'(k * 40503 + seed * 977 + lane * 12345 + (k >> 3));
  endfunction

  task automatic put_bit(input logic b0, input logic b1);
    @(negedge clk); sclk = 1'b0; sd0 = b0; sd1 = b1;
    @(negedge clk);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
  endtask

  // one transfer on both lanes; n data words, extra = trailing partial bits
  task automatic send(input logic [15:0] c0, input logic [15:0] c1,
                      input int n, input int seed, input int extra);
    logic [15:0] w0, w1;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int w = 0; w <= n; w++) begin
      w0 = (w == 0) ? c0 : dw(0, seed, w - 1);
      w1 = (w == 0) ? c1 : dw(1, seed, w - 1);
      for (int b = 15; b >= 0; b--) put_bit(w0[b], w1[b]);
    end
    for (int e = 0; e < extra; e++) put_bit(1'b1, 1'b1);
    @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    // reference model: lane 0 before lane 1 for each word slot
    exp_err = 2'b00;
    for (int w = 0; w < n; w++) begin
      for (int l = 0; l < 2; l++) begin
        logic [15:0] c;
        c = (l == 0) ? c0 : c1;
        if ((l == 0 || dual_en) && !c[15]) begin
          if (c[14:12] == 3'b110) expm[12'(c[11:0] + w)] = dw(l, seed, w) >> 4;
          else exp_err[l] = 1'b1;
        end
      end
    end
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(req, {19'd0, rd_valid, rd_data}, {19'd0, 1'b1, expm[a]});
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dual_en = 1'b1; sclk = 1'b0; cs_n = 1'b1;
    sd0 = 1'b0; sd1 = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R11 addr_err", {30'd0, addr_err}, 32'd0);
    check("R11 rd_ready", {31'd0, rd_ready}, 32'd1);

    // R1 R2 R3 R4 R5: full fill, both lanes, simultaneous completions
    send(16'h6000, 16'h6800, 2048, 1, 0);
    check("R3 no error on fill", {30'd0, addr_err}, 32'd0);
    for (int a = 0; a < 4096; a++) rd(12'(a), "R1/R4 full readback");

    // R5 same address on both lanes: lane 1 value remains
    send(16'h6100, 16'h6100, 3, 7, 0);
    for (int a = 12'h100; a < 12'h103; a++) rd(12'(a), "R5 overlap");
    check("R5 lane1 wins", {20'd0, expm[12'h100]}, {20'd0, 12'(dw(1, 7, 0) >> 4)});

    // R6 wrap at top of window
    send(16'h6FFE, 16'h6010, 4, 3, 0);
    rd(12'hFFE, "R6 wrap"); rd(12'hFFF, "R6 wrap");
    rd(12'h000, "R6 wrap"); rd(12'h001, "R6 wrap");
    rd(12'h010, "R6 lane1"); rd(12'h013, "R6 lane1");

    // R7 out-of-window command on lane 1
    send(16'h6200, 16'h7004, 2, 11, 0);
    check("R7 error flag", {30'd0, addr_err}, {30'd0, exp_err});
    check("R7 expected flag", {30'd0, exp_err}, 32'd2);
    rd(12'h004, "R7 no write"); rd(12'h005, "R7 no write");
    rd(12'h200, "R7 lane0 ok");
    // R7 flag clears at next select
    send(16'h6220, 16'h6230, 1, 12, 0);
    check("R7 flag cleared", {30'd0, addr_err}, 32'd0);

    // R8 read command on lane 0 ignored, lane 1 still writes
    send(16'hE300, 16'h6400, 2, 13, 0);
    check("R8 no error", {30'd0, addr_err}, 32'd0);
    rd(12'h300, "R8 untouched"); rd(12'h301, "R8 untouched");
    rd(12'h400, "R8 lane1"); rd(12'h401, "R8 lane1");

    // R9 single-lane mode: lane 1 ignored even with bad address
    dual_en = 1'b0;
    send(16'h6500, 16'h1600, 2, 17, 0);
    check("R9 no lane1 error", {30'd0, addr_err}, 32'd0);
    send(16'h6510, 16'h6600, 2, 18, 0);
    rd(12'h500, "R9 lane0"); rd(12'h511, "R9 lane0");
    rd(12'h600, "R9 lane1 untouched"); rd(12'h601, "R9 lane1 untouched");
    dual_en = 1'b1;

    // R12 partial word discarded, next transfer restarts with a command
    send(16'h6700, 16'h6780, 1, 21, 5);
    send(16'h6710, 16'h6790, 1, 22, 0);
    rd(12'h700, "R12 first"); rd(12'h701, "R12 partial dropped");
    rd(12'h710, "R12 restart"); rd(12'h790, "R12 restart lane1");

    // R10 idle read port
    check("R10 ready idle", {31'd0, rd_ready}, 32'd1);
    @(negedge clk);
    check("R10 no valid without request", {31'd0, rd_valid}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule